// File: doc/BRIEF.md
# Wide register host access bridge

This bridge connects a 32-bit host register bus to a bank of 128-bit internal control registers and to a window onto an SRAM made of 64-bit words. A wide value cannot move across the host bus in one access, so the bridge splits it into dwords. On the read side, a snapshot latch captures a whole register at once. On the write side, a collector gathers dwords and commits the register only when it is complete. This way the host never sees a torn value, and an internal register never receives a half-written one.

Two write-only doorbell registers, one per descriptor queue direction, follow relaxed rules so that the host needs no lock for them. Writing a doorbell's top dword always commits it. Any low dword that the collector does not hold for that doorbell is committed as zero. A low-dword doorbell write that would disturb another register's pending collection is dropped. Doorbells are repeated in every 0x2000-byte page. A timer-command dword in page 0 clears the collector as a side effect. Plain 32-bit registers pass straight through. Every host request is acknowledged exactly one cycle after it is issued.

Top module: `wreg_bridge`

## Requirements
- R1: A wide register at page-0 offset 16*n (n below NWIDE) is written to its bank only when all four of its dwords have been collected, in any order. The commit is a one-cycle `wide_wr_stb` issued one cycle after the completing write, with `wide_wr_idx`=n and `wr_data` bits [32k+31:32k] taken from the dword at byte offset 4k.
- R2: A write to a different wide register or SRAM word while a collection is pending discards the pending dwords and starts collecting for the new target.
- R3: A read of dword 0 of a wide register, or of any dword of a register other than the latched one, captures the whole register and pulses `wide_rd_cap` in the request cycle. A later read of a higher dword of the latched register returns latched data with no capture, even if the bank has since changed.
- R4: SRAM word w at page-0 offset 0x1000+8*w uses the same rules with two dwords. Its commit pulses `sram_wr_stb` with `sram_wr_idx`=w and the word in `wr_data[63:0]` (upper bits zero). Its reads capture through `sram_rd_cap`.
- R5: A write to a doorbell's top dword (offset 0xC within the doorbell) always commits through `db_wr_stb` one cycle later. Bits [127:96] carry the written value. Each lower dword carries the value collected for that same doorbell, or zero if none was collected. A collection pending for a different register is left intact.
- R6: A write to a low doorbell dword while the collector holds dwords of a different register is dropped, and the collector keeps its contents.
- R7: The doorbells sit at page*0x2000+0x830 (`db_wr_sel`=0) and page*0x2000+0xA10 (`db_wr_sel`=1). `db_wr_page` reports the page.
- R8: A write to offset 0x420 in page 0 empties the collector. The same write in any other page does not affect it.
- R9: Plain dwords at page*0x2000+0x400+4*i (i below NPLAIN) bypass the latch and collector. A write pulses `dw_wr_stb` in the request cycle with `dw_wdata`, `dw_idx`=i and `dw_page`. A read returns `dw_rdata`.
- R10: Every request raises `host_ack` for exactly one cycle, one cycle later, with read data in `host_rdata`. Doorbell and unmapped reads return zero.
- R11: While reset is held, `host_ack` and all commit strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 32 | Host write dword |
| host_ack | output | 1 | Access completion, one cycle after the request |
| host_rdata | output | 32 | Read dword, valid with host_ack |
| wide_rd_idx | output | WIW | Wide register index presented to the bank |
| wide_rd_data | input | 128 | Current value of the indexed wide register |
| wide_rd_cap | output | 1 | Wide register captured this cycle (read side effects) |
| sram_rd_idx | output | SIW | SRAM word index presented to the SRAM |
| sram_rd_data | input | 64 | Current value of the indexed SRAM word |
| sram_rd_cap | output | 1 | SRAM word captured this cycle |
| dw_idx | output | PIW | Plain dword index |
| dw_page | output | PW | Page of the plain dword access |
| dw_wr_stb | output | 1 | Plain dword write strobe |
| dw_wdata | output | 32 | Plain dword write data |
| dw_rdata | input | 32 | Plain dword read data |
| wide_wr_stb | output | 1 | Wide register commit strobe |
| wide_wr_idx | output | WIW | Index of the committed wide register |
| sram_wr_stb | output | 1 | SRAM word commit strobe |
| sram_wr_idx | output | SIW | Index of the committed SRAM word |
| db_wr_stb | output | 1 | Doorbell commit strobe |
| db_wr_sel | output | 1 | Committed doorbell, 0 at 0x830, 1 at 0xA10 |
| db_wr_page | output | PW | Page of the committed doorbell |
| wr_data | output | 128 | Committed data |

## Verification
The interesting overlap comes when a doorbell top-dword commit and a pending collection share one cycle. In that cycle the collector must both supply lower dwords to the doorbell and keep, or release, its hold on another register. The bench provokes this in two ways: it collects part of a doorbell and then writes its top dword, and it interleaves a doorbell access into a half-collected wide register. It then judges the outcome from the zero-filled or merged doorbell data and from the later commit of the interrupted register with its original dwords.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_WIDE,
    K_SRAM,
    K_DB,
    K_PLAIN
  } kind_e;

  localparam int unsigned PAGE_LG = 13;

  localparam logic [12:0] OFS_PLAIN = 13'h0400;
  localparam logic [12:0] OFS_TIMER = 13'h0420;
  localparam logic [12:0] OFS_DB0   = 13'h0830;
  localparam logic [12:0] OFS_DB1   = 13'h0A10;
  localparam logic [12:0] OFS_SRAM  = 13'h1000;

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
  import wrb_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NWIDE  = 16,
  parameter int NSRAM  = 64,
  parameter int NPLAIN = 16,
  localparam int WIW   = $clog2(NWIDE),
  localparam int SIW   = $clog2(NSRAM),
  localparam int PIW   = $clog2(NPLAIN),
  localparam int PW    = AW - PAGE_LG,
  localparam int TW    = AW - 3
) (
  input  logic [AW-1:0]  addr,
  output kind_e          kind,
  output logic [1:0]     dw,
  output logic [TW-1:0]  tag,
  output logic [WIW-1:0] wide_idx,
  output logic [SIW-1:0] sram_idx,
  output logic [PIW-1:0] plain_idx,
  output logic [PW-1:0]  page,
  output logic           db_sel,
  output logic           timer_p0
);

  logic [12:0] ofs;
  logic        pg0, in_wide, in_sram, in_plain, in_db;
  logic [1:0]  addr_lsb_unused;

  assign ofs             = addr[12:0];
  assign page            = addr[AW-1:PAGE_LG];
  assign addr_lsb_unused = addr[1:0];
  assign pg0             = (page == '0);

  assign in_wide  = pg0 && (ofs < 13'(NWIDE * 16));
  assign in_sram  = pg0 && (ofs >= OFS_SRAM) && (ofs < OFS_SRAM + 13'(NSRAM * 8));
  assign in_plain = (ofs >= OFS_PLAIN) && (ofs < OFS_PLAIN + 13'(NPLAIN * 4));
  assign in_db    = (ofs[12:4] == OFS_DB0[12:4]) || (ofs[12:4] == OFS_DB1[12:4]);

  always_comb begin
    if (in_wide)       kind = K_WIDE;
    else if (in_plain) kind = K_PLAIN;
    else if (in_db)    kind = K_DB;
    else if (in_sram)  kind = K_SRAM;
    else               kind = K_NONE;
  end

  assign dw        = (kind == K_SRAM) ? {1'b0, addr[2]} : addr[3:2];
  assign tag       = {addr[AW-1:4], (kind == K_SRAM) ? addr[3] : 1'b0};
  assign wide_idx  = ofs[4 +: WIW];
  assign sram_idx  = ofs[3 +: SIW];
  assign plain_idx = ofs[2 +: PIW];
  assign db_sel    = (ofs[12:4] == OFS_DB1[12:4]);
  assign timer_p0  = pg0 && (ofs[12:2] == OFS_TIMER[12:2]);

endmodule

// File: rtl/wrb_collector.sv
module wrb_collector
  import wrb_pkg::*;
#(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  kind_e         kind,
  input  logic [1:0]    dw,
  input  logic [TW-1:0] tag,
  input  logic [31:0]   wdata,
  input  logic          inval,
  output logic          cmt_wide,
  output logic          cmt_sram,
  output logic          cmt_db,
  output logic [127:0]  cmt_data
);

  logic [3:0]    mask_q, mask_d;
  logic [TW-1:0] tag_q, tag_d;
  logic [127:0]  data_q, data_d;
  logic          ld;
  logic          cw_d, cs_d, cd_d;
  logic [127:0]  cdat_d;

  logic          hit;
  logic [3:0]    base_m, m;
  logic [127:0]  merged;
  logic          full;

  assign hit    = (|mask_q) && (tag_q == tag);
  assign base_m = hit ? mask_q : 4'h0;
  assign m      = base_m | (4'b0001 << dw);
  assign full   = (kind == K_SRAM) ? (m[1:0] == 2'b11) : (m == 4'hF);

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      if (2'(j) == dw)    merged[32*j +: 32] = wdata;
      else if (base_m[j]) merged[32*j +: 32] = data_q[32*j +: 32];
      else                merged[32*j +: 32] = 32'h0;
    end
  end

  always_comb begin
    mask_d = mask_q;
    tag_d  = tag_q;
    data_d = data_q;
    ld     = 1'b0;
    cw_d   = 1'b0;
    cs_d   = 1'b0;
    cd_d   = 1'b0;
    cdat_d = merged;
    if (wr_en) begin
      unique case (kind)
        K_WIDE, K_SRAM: begin
          if (full) begin
            cw_d   = (kind == K_WIDE);
            cs_d   = (kind == K_SRAM);
            mask_d = 4'h0;
          end else begin
            mask_d = m;
            tag_d  = tag;
            data_d = merged;
            ld     = 1'b1;
          end
        end
        K_DB: begin
          if (dw == 2'd3) begin
            cd_d = 1'b1;
            if (hit) mask_d = 4'h0;
          end else if (!((|mask_q) && !hit)) begin
            mask_d = m;
            tag_d  = tag;
            data_d = merged;
            ld     = 1'b1;
          end
        end
        K_PLAIN: begin
          if (inval) mask_d = 4'h0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= 4'h0;
      cmt_wide <= 1'b0;
      cmt_sram <= 1'b0;
      cmt_db   <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      cmt_wide <= cw_d;
      cmt_sram <= cs_d;
      cmt_db   <= cd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      tag_q  <= tag_d;
      data_q <= data_d;
    end
    if (cw_d || cs_d || cd_d) cmt_data <= cdat_d;
  end

endmodule

// File: rtl/wrb_rdlatch.sv
module wrb_rdlatch
  import wrb_pkg::*;
#(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  kind_e         kind,
  input  logic [1:0]    dw,
  input  logic [TW-1:0] tag,
  input  logic [127:0]  wide_data,
  input  logic [63:0]   sram_data,
  output logic          cap_wide,
  output logic          cap_sram,
  output logic [31:0]   rword
);

  logic          lat_v;
  logic [TW-1:0] lat_tag;
  logic [127:0]  lat_data;
  logic          wide_sel, need, cap;
  logic [127:0]  src;

  assign wide_sel = (kind == K_WIDE);
  assign need     = rd_en && (wide_sel || (kind == K_SRAM));
  assign cap      = need && ((dw == 2'd0) || !lat_v || (lat_tag != tag));
  assign cap_wide = cap && wide_sel;
  assign cap_sram = cap && !wide_sel;
  assign src      = wide_sel ? wide_data : {64'h0, sram_data};
  assign rword    = cap ? src[{dw, 5'b0} +: 32] : lat_data[{dw, 5'b0} +: 32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_v <= 1'b0;
    else if (cap) lat_v <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      lat_tag  <= tag;
      lat_data <= src;
    end
  end

endmodule

// File: rtl/wreg_bridge.sv
module wreg_bridge
  import wrb_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NWIDE  = 16,
  parameter int NSRAM  = 64,
  parameter int NPLAIN = 16,
  localparam int WIW   = $clog2(NWIDE),
  localparam int SIW   = $clog2(NSRAM),
  localparam int PIW   = $clog2(NPLAIN),
  localparam int PW    = AW - PAGE_LG,
  localparam int TW    = AW - 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_req,
  input  logic           host_we,
  input  logic [AW-1:0]  host_addr,
  input  logic [31:0]    host_wdata,
  output logic           host_ack,
  output logic [31:0]    host_rdata,
  output logic [WIW-1:0] wide_rd_idx,
  input  logic [127:0]   wide_rd_data,
  output logic           wide_rd_cap,
  output logic [SIW-1:0] sram_rd_idx,
  input  logic [63:0]    sram_rd_data,
  output logic           sram_rd_cap,
  output logic [PIW-1:0] dw_idx,
  output logic [PW-1:0]  dw_page,
  output logic           dw_wr_stb,
  output logic [31:0]    dw_wdata,
  input  logic [31:0]    dw_rdata,
  output logic           wide_wr_stb,
  output logic [WIW-1:0] wide_wr_idx,
  output logic           sram_wr_stb,
  output logic [SIW-1:0] sram_wr_idx,
  output logic           db_wr_stb,
  output logic           db_wr_sel,
  output logic [PW-1:0]  db_wr_page,
  output logic [127:0]   wr_data
);

  kind_e          kind;
  logic [1:0]     dw;
  logic [TW-1:0]  tag;
  logic [WIW-1:0] wide_idx;
  logic [SIW-1:0] sram_idx;
  logic [PIW-1:0] plain_idx;
  logic [PW-1:0]  page;
  logic           db_sel, timer_p0;
  logic           rd_en, wr_en;
  logic [31:0]    lat_word, rdata_d;

  assign rd_en = host_req && !host_we;
  assign wr_en = host_req && host_we;

  wrb_decode #(.AW(AW), .NWIDE(NWIDE), .NSRAM(NSRAM), .NPLAIN(NPLAIN)) u_dec (
    .addr      (host_addr),
    .kind      (kind),
    .dw        (dw),
    .tag       (tag),
    .wide_idx  (wide_idx),
    .sram_idx  (sram_idx),
    .plain_idx (plain_idx),
    .page      (page),
    .db_sel    (db_sel),
    .timer_p0  (timer_p0)
  );

  wrb_collector #(.TW(TW)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .kind     (kind),
    .dw       (dw),
    .tag      (tag),
    .wdata    (host_wdata),
    .inval    (timer_p0),
    .cmt_wide (wide_wr_stb),
    .cmt_sram (sram_wr_stb),
    .cmt_db   (db_wr_stb),
    .cmt_data (wr_data)
  );

  wrb_rdlatch #(.TW(TW)) u_lat (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .kind      (kind),
    .dw        (dw),
    .tag       (tag),
    .wide_data (wide_rd_data),
    .sram_data (sram_rd_data),
    .cap_wide  (wide_rd_cap),
    .cap_sram  (sram_rd_cap),
    .rword     (lat_word)
  );

  assign wide_rd_idx = wide_idx;
  assign sram_rd_idx = sram_idx;
  assign dw_idx      = plain_idx;
  assign dw_page     = page;
  assign dw_wdata    = host_wdata;
  assign dw_wr_stb   = wr_en && (kind == K_PLAIN);

  always_comb begin
    unique case (kind)
      K_WIDE, K_SRAM: rdata_d = lat_word;
      K_PLAIN:        rdata_d = dw_rdata;
      default:        rdata_d = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_ack <= 1'b0;
    else        host_ack <= host_req;
  end

  always_ff @(posedge clk) begin
    if (rd_en) host_rdata <= rdata_d;
    if (wr_en) begin
      wide_wr_idx <= wide_idx;
      sram_wr_idx <= sram_idx;
      db_wr_sel   <= db_sel;
      db_wr_page  <= page;
    end
  end

endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
  parameter int AW = 16,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req,
  input logic          host_we,
  input logic [AW-1:0] host_addr,
  input logic          host_ack,
  input logic [31:0]   host_rdata,
  input logic          wide_rd_cap,
  input logic          sram_rd_cap,
  input logic          dw_wr_stb,
  input logic          wide_wr_stb,
  input logic          sram_wr_stb,
  input logic          db_wr_stb,
  input logic [PW-1:0] db_wr_page
);

  logic [12:0] ofs;
  logic        is_db, is_db_top;

  assign ofs       = host_addr[12:0];
  assign is_db     = (ofs[12:4] == 9'h083) || (ofs[12:4] == 9'h0A1);
  assign is_db_top = is_db && (ofs[3:2] == 2'd3);

  a_r10_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |=> host_ack);

  a_r10_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |=> !host_ack);

  a_r10_db_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && is_db) |=> (host_rdata == 32'h0));

  a_r1_commit_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_wr_stb || sram_wr_stb || db_wr_stb) |-> $past(host_req && host_we));

  a_r1_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wide_wr_stb, sram_wr_stb, db_wr_stb}));

  a_r5_db_top_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && is_db_top) |=> db_wr_stb);

  a_r7_db_page: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && is_db_top) |=> (db_wr_page == $past(host_addr[AW-1:13])));

  a_r3_capture_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_rd_cap || sram_rd_cap) |-> (host_req && !host_we));

  a_r9_plain_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    dw_wr_stb |-> (host_req && host_we));

endmodule

bind wreg_bridge wrb_checker #(.AW(AW), .PW(PW)) u_wrb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_req    (host_req),
  .host_we     (host_we),
  .host_addr   (host_addr),
  .host_ack    (host_ack),
  .host_rdata  (host_rdata),
  .wide_rd_cap (wide_rd_cap),
  .sram_rd_cap (sram_rd_cap),
  .dw_wr_stb   (dw_wr_stb),
  .wide_wr_stb (wide_wr_stb),
  .sram_wr_stb (sram_wr_stb),
  .db_wr_stb   (db_wr_stb),
  .db_wr_page  (db_wr_page)
);

// File: tb/wreg_bridge_tb_top.sv
module wreg_bridge_tb_top;

  logic          clk, rst_n;
  logic          host_req, host_we;
  logic [15:0]   host_addr;
  logic [31:0]   host_wdata;
  logic          host_ack;
  logic [31:0]   host_rdata;
  logic [3:0]    wide_rd_idx;
  logic [127:0]  wide_rd_data;
  logic          wide_rd_cap;
  logic [5:0]    sram_rd_idx;
  logic [63:0]   sram_rd_data;
  logic          sram_rd_cap;
  logic [3:0]    dw_idx;
  logic [2:0]    dw_page;
  logic          dw_wr_stb;
  logic [31:0]   dw_wdata, dw_rdata;
  logic          wide_wr_stb, sram_wr_stb, db_wr_stb, db_wr_sel;
  logic [3:0]    wide_wr_idx;
  logic [5:0]    sram_wr_idx;
  logic [2:0]    db_wr_page;
  logic [127:0]  wr_data;

  logic [127:0] wbank [16];
  logic [63:0]  sbank [64];

  assign wide_rd_data = wbank[wide_rd_idx];
  assign sram_rd_data = sbank[sram_rd_idx];
  assign dw_rdata     = {16'hC0DE, 9'h0, dw_page, dw_idx};

  wreg_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .wide_rd_idx(wide_rd_idx), .wide_rd_data(wide_rd_data), .wide_rd_cap(wide_rd_cap),
    .sram_rd_idx(sram_rd_idx), .sram_rd_data(sram_rd_data), .sram_rd_cap(sram_rd_cap),
    .dw_idx(dw_idx), .dw_page(dw_page), .dw_wr_stb(dw_wr_stb),
    .dw_wdata(dw_wdata), .dw_rdata(dw_rdata),
    .wide_wr_stb(wide_wr_stb), .wide_wr_idx(wide_wr_idx),
    .sram_wr_stb(sram_wr_stb), .sram_wr_idx(sram_wr_idx),
    .db_wr_stb(db_wr_stb), .db_wr_sel(db_wr_sel), .db_wr_page(db_wr_page),
    .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic         c_capw, c_caps, c_dws;
  logic [31:0]  c_dwd;
  logic         r_ack;
  logic [31:0]  r_rd;
  logic [2:0]   r_stb;
  logic [127:0] r_data;

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    #1;
    c_capw = wide_rd_cap; c_caps = sram_rd_cap; c_dws = dw_wr_stb; c_dwd = dw_wdata;
    @(posedge clk);
    #1;
    r_ack = host_ack; r_rd = host_rdata;
    r_stb = {wide_wr_stb, sram_wr_stb, db_wr_stb};
    r_data = wr_data;
    host_req = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [31:0] wd;
    logic [2:0]  stb;
    logic        dws;
    logic [31:0] rd;
  } vec_t;

  localparam vec_t VT [14] = '{
    '{1'b1, 16'h0404, 32'h12345678, 3'b000, 1'b1, 32'h0},          // R9 plain write
    '{1'b0, 16'h0404, 32'h0,        3'b000, 1'b0, 32'hC0DE0001},   // R9 plain read
    '{1'b0, 16'h2408, 32'h0,        3'b000, 1'b0, 32'hC0DE0012},   // R9 page 1
    '{1'b0, 16'h0830, 32'h0,        3'b000, 1'b0, 32'h0},          // R10 doorbell read
    '{1'b0, 16'h4A14, 32'h0,        3'b000, 1'b0, 32'h0},          // R10 doorbell read
    '{1'b0, 16'h0800, 32'h0,        3'b000, 1'b0, 32'h0},          // R10 unmapped
    '{1'b0, 16'h0060, 32'h0,        3'b000, 1'b0, 32'hA0000600},   // R3 dword 0
    '{1'b0, 16'h0068, 32'h0,        3'b000, 1'b0, 32'hA0000602},   // R3 dword 2
    '{1'b1, 16'h0050, 32'h50,       3'b000, 1'b0, 32'h0},          // R1
    '{1'b1, 16'h0054, 32'h51,       3'b000, 1'b0, 32'h0},
    '{1'b1, 16'h0058, 32'h52,       3'b000, 1'b0, 32'h0},
    '{1'b1, 16'h005C, 32'h53,       3'b100, 1'b0, 32'h0},          // R1 commit
    '{1'b1, 16'h1010, 32'h60,       3'b000, 1'b0, 32'h0},          // R4
    '{1'b1, 16'h1014, 32'h61,       3'b010, 1'b0, 32'h0}           // R4 commit
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 4; j++)
        wbank[i][32*j +: 32] = 32'hA000_0000 | 32'(i << 8) | 32'(j);
    for (int i = 0; i < 64; i++)
      sbank[i] = {32'hB000_0001 | 32'(i << 8), 32'hB000_0000 | 32'(i << 8)};
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 ack in reset", 128'(host_ack), 128'h0);
    chk("R11 strobes in reset", 128'({wide_wr_stb, sram_wr_stb, db_wr_stb}), 128'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < 14; k++) begin
      op(VT[k].we, VT[k].addr, VT[k].wd);
      chk($sformatf("R10 ack row %0d", k), 128'(r_ack), 128'h1);
      chk($sformatf("R1 R4 strobes row %0d", k), 128'(r_stb), 128'(VT[k].stb));
      chk($sformatf("R9 plain strobe row %0d", k), 128'(c_dws), 128'(VT[k].dws));
      if (!VT[k].we) chk($sformatf("R10 rdata row %0d", k), 128'(r_rd), 128'(VT[k].rd));
    end

    // R1: any order
    op(1, 16'h007C, 32'h7003); chk("R1 no early commit", 128'(r_stb), 128'h0);
    op(1, 16'h0074, 32'h7001); chk("R1 no early commit", 128'(r_stb), 128'h0);
    op(1, 16'h0070, 32'h7000); chk("R1 no early commit", 128'(r_stb), 128'h0);
    op(1, 16'h0078, 32'h7002);
    chk("R1 commit strobe", 128'(r_stb), 128'b100);
    chk("R1 commit data", r_data, {32'h7003, 32'h7002, 32'h7001, 32'h7000});
    chk("R1 commit index", 128'(wide_wr_idx), 128'd7);

    // R2: retarget drops partial data
    op(1, 16'h0080, 32'h8800); op(1, 16'h0084, 32'h8801);
    op(1, 16'h0090, 32'h9900); op(1, 16'h0094, 32'h9901);
    op(1, 16'h0098, 32'h9902); op(1, 16'h009C, 32'h9903);
    chk("R2 new target commit", r_data, {32'h9903, 32'h9902, 32'h9901, 32'h9900});
    op(1, 16'h0088, 32'h8802); op(1, 16'h008C, 32'h8803);
    chk("R2 old dwords dropped", 128'(r_stb), 128'h0);
    op(1, 16'h0080, 32'h8810); op(1, 16'h0084, 32'h8811);
    chk("R2 strobe", 128'(r_stb), 128'b100);
    chk("R2 data", r_data, {32'h8803, 32'h8802, 32'h8811, 32'h8810});
    chk("R2 index", 128'(wide_wr_idx), 128'd8);

    // R3: read latch
    op(0, 16'h0040, 0);
    chk("R3 capture dword0", 128'(c_capw), 128'h1);
    chk("R3 data dword0", 128'(r_rd), 128'hA0000400);
    wbank[4][63:32] = 32'h5555_0001;
    op(0, 16'h0044, 0);
    chk("R3 no capture", 128'(c_capw), 128'h0);
    chk("R3 latched data", 128'(r_rd), 128'hA0000401);
    op(0, 16'h0038, 0);
    chk("R3 capture other reg", 128'(c_capw), 128'h1);
    chk("R3 other reg data", 128'(r_rd), 128'hA0000302);
    op(0, 16'h0044, 0);
    chk("R3 recapture", 128'(c_capw), 128'h1);
    chk("R3 fresh data", 128'(r_rd), 128'h55550001);

    // R4: SRAM latch and commit
    op(0, 16'h102C, 0);
    chk("R4 capture", 128'(c_caps), 128'h1);
    chk("R4 data", 128'(r_rd), 128'hB0000501);
    sbank[5][63:32] = 32'h7777_0000;
    op(0, 16'h102C, 0);
    chk("R4 latched no capture", 128'(c_caps), 128'h0);
    chk("R4 latched data", 128'(r_rd), 128'hB0000501);
    op(1, 16'h1028, 32'h5A00); op(1, 16'h102C, 32'h5A01);
    chk("R4 strobe", 128'(r_stb), 128'b010);
    chk("R4 commit data", r_data, {64'h0, 32'h5A01, 32'h5A00});
    chk("R4 index", 128'(sram_wr_idx), 128'd5);

    // R5: doorbell merge and zero fill
    op(1, 16'h4830, 32'hD0); op(1, 16'h4838, 32'hD2);
    chk("R5 no commit on low dword", 128'(r_stb), 128'h0);
    op(1, 16'h483C, 32'hD3);
    chk("R5 strobe", 128'(r_stb), 128'b001);
    chk("R5 merged data", r_data, {32'hD3, 32'hD2, 32'h0, 32'hD0});
    chk("R7 sel", 128'(db_wr_sel), 128'h0);
    chk("R7 page", 128'(db_wr_page), 128'd2);
    op(1, 16'h483C, 32'hE3);
    chk("R5 zero fill", r_data, {32'hE3, 96'h0});

    // R6: discard low doorbell dword with foreign collection
    op(1, 16'h0020, 32'hC0); op(1, 16'h0024, 32'hC1);
    op(1, 16'h0A10, 32'hF0);
    chk("R6 discarded no strobe", 128'(r_stb), 128'h0);
    op(1, 16'h0A1C, 32'hF3);
    chk("R6 discarded dword absent", r_data, {32'hF3, 96'h0});
    chk("R7 sel 1", 128'(db_wr_sel), 128'h1);
    op(1, 16'h0028, 32'hC2); op(1, 16'h002C, 32'hC3);
    chk("R6 collection kept", r_data, {32'hC3, 32'hC2, 32'hC1, 32'hC0});
    chk("R5 collection kept strobe", 128'(r_stb), 128'b100);

    // R7: page 5
    op(1, 16'hAA1C, 32'h6603);
    chk("R7 strobe", 128'(r_stb), 128'b001);
    chk("R7 page 5", 128'(db_wr_page), 128'd5);
    chk("R7 sel page 5", 128'(db_wr_sel), 128'h1);

    // R8: timer command invalidation
    op(1, 16'h00B0, 32'hB0); op(1, 16'h00B4, 32'hB1); op(1, 16'h00B8, 32'hB2);
    op(1, 16'h0420, 32'h1);
    op(1, 16'h00BC, 32'hB3);
    chk("R8 page0 invalidates", 128'(r_stb), 128'h0);
    op(1, 16'h00B0, 32'hBA); op(1, 16'h00B4, 32'hBB); op(1, 16'h00B8, 32'hBC);
    chk("R8 commit after refill", r_data, {32'hB3, 32'hBC, 32'hBB, 32'hBA});
    op(1, 16'h00C0, 32'hC0); op(1, 16'h00C4, 32'hC1); op(1, 16'h00C8, 32'hC2);
    op(1, 16'h2420, 32'h1);
    op(1, 16'h00CC, 32'hC3);
    chk("R8 other page keeps", 128'(r_stb), 128'b100);
    chk("R8 other page data", r_data, {32'hC3, 32'hC2, 32'hC1, 32'hC0});

    // R9: plain write in the middle of a collection
    op(1, 16'h00A0, 32'hA0); op(1, 16'h00A4, 32'hA1);
    op(1, 16'h0408, 32'hFEED);
    chk("R9 plain strobe", 128'(c_dws), 128'h1);
    chk("R9 plain data", 128'(c_dwd), 128'hFEED);
    op(1, 16'h00A8, 32'hA2); op(1, 16'h00AC, 32'hA3);
    chk("R9 bypass keeps collection", r_data, {32'hA3, 32'hA2, 32'hA1, 32'hA0});

    // R10: single-cycle ack
    @(negedge clk); @(negedge clk);
    chk("R10 ack drops", 128'(host_ack), 128'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule